// File: doc/BRIEF.md
# Timestamped Word Error Logger

The logger watches an 18-bit word stream from a device under test. Each word carries 16 payload bits and 2 control-character flags. Every word is compared with the word that a reference pattern source expects in the same clock. Time is split into repeating test units. Each unit opens with an active window, in which words are compared, and closes with a powerdown window. During powerdown the block asserts a powerdown control so that external equipment can measure static current. Every mismatch is logged with its cycle offset inside the current unit, together with the expected word and the received word. The flipped bits are therefore the XOR of the two.

Runs of consecutive errored words are tracked. When a run ends, a single-error record is emitted for a run of length one and a burst record for a longer run. Either record carries the run length and the offset of the first errored word. On the last cycle of each unit the block emits a summary record with these fields:
- the unit number
- the saturating error total
- the single-error and burst counts
- the number of records lost to back-pressure
- a failure flag, raised when the total exceeds a threshold

All records leave through one valid/ready stream, which is fed from a small internal FIFO.

With the defaults the word clock is 100 MHz and a unit lasts 10 s: 950,000,000 compare cycles and then 50,000,000 powerdown cycles. Both lengths are parameters, so that short units can be used.

Top module: `word_err_logger`

## Requirements
- R1: While reset is held low, `rec_valid` and `pd_o` are low. In the first cycle after release the unit offset is 0.
- R2: A unit lasts ACT_CYC+PD_CYC cycles. `pd_o` is high exactly at offsets ACT_CYC to ACT_CYC+PD_CYC-1, and the offset returns to 0 after the last of them.
- R3: During powerdown, `rx_word` is ignored. No word record and no error count results, whatever the received value.
- R4: A mismatch at offset t produces a record of kind 0. Its payload is {t, expected, received}, with the received word in bits DW-1:0 and the expected word in bits 2*DW-1:DW.
- R5: A run of errored words produces one record in the cycle after its last word, or in the first powerdown cycle if the run reaches the end of the active window. The kind is 1 for length one and 2 otherwise, and the payload is {first offset, length}, with the length in bits CNT_W-1:0.
- R6: In the last cycle of a unit a record of kind 3 is produced with payload {unit number, total, singles, bursts, drops, fail}, where fail is bit 0 and each count is CNT_W bits wide. All per-unit counts are then cleared and the unit number increments.
- R7: The fail bit is 1 only when the unit's total exceeds FAIL_LIM. A total equal to FAIL_LIM gives 0.
- R8: The error total and the run length saturate at 2^CNT_W-1.
- R9: A word or run record is accepted only while the FIFO holds fewer than FIFO_DEPTH-1 entries. A rejected record is counted in the drop field of the summary, and the summary uses the reserved last entry.
- R10: Records leave in the order in which they were produced. While `rec_valid` is high and `rec_ready` is low, `rec_data` holds its value.
- R11: A difference in any of the 18 bits, including the two control-flag bits 17:16, counts as a mismatch.
- The record kind sits in the top two bits of `rec_data` in every record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_word | input | DW | Word received from the device under test |
| ref_word | input | DW | Word expected in the same cycle |
| pd_o | output | 1 | Powerdown control, high during the powerdown window |
| rec_valid | output | 1 | Log record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_data | output | REC_W | Record: kind in the top two bits, payload below |

## Verification
If the offset counter is wrong, the damage shows as shifted timestamps in the very next word record, and as `pd_o` moving away from its window within one unit. If the run tracker or the per-unit counters are wrong, nothing shows until the next run record or the next summary, which can be as late as the end of the unit. Clearing faults between units appear in the following summary. FIFO occupancy faults show as reordered or lost records, or as a wrong drop count, during the first stalled stretch that fills the queue.

// File: rtl/wel_pkg.sv
// Shared definitions for the word error logger.
// Assumes: record kind occupies the top two bits of every record.
package wel_pkg;
    typedef enum logic [1:0] {
        REC_WORD    = 2'd0,
        REC_SINGLE  = 2'd1,
        REC_BURST   = 2'd2,
        REC_SUMMARY = 2'd3
    } wel_kind_e;

    // Larger of two widths, used to size the common payload field.
    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/wel_timebase.sv
// Unit timebase: counts cycle offsets within a test unit and marks the
// powerdown window and the last cycle of the unit.
// Assumes: PD_CYC >= 2 so a run closed at powerdown entry never coincides
// with the end-of-unit summary.
module wel_timebase #(
    parameter int unsigned ACT_CYC = 950_000_000,
    parameter int unsigned PD_CYC  = 50_000_000,
    parameter int          TS_W    = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts,
    output logic            pd,
    output logic            unit_end
);
    localparam logic [TS_W-1:0] LAST_TS = TS_W'(ACT_CYC + PD_CYC - 1);
    localparam logic [TS_W-1:0] PD_TS   = TS_W'(ACT_CYC);

    // Offset counter, wraps at the end of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n)         ts <= '0;
        else if (unit_end)  ts <= '0;
        else                ts <= ts + 1'b1;
    end

    // Window decode from the offset.
    always_comb begin
        pd       = (ts >= PD_TS);
        unit_end = (ts == LAST_TS);
    end
endmodule

// File: rtl/wel_run_track.sv
// Run tracker: follows consecutive errored words and reports each run
// (first offset, saturating length) in the cycle after it ends.
// Assumes: hit is already gated off during powerdown.
module wel_run_track #(
    parameter int TS_W  = 30,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [TS_W-1:0]  ts,
    output logic             in_run,
    output logic             close,
    output logic [CNT_W-1:0] run_len,
    output logic [TS_W-1:0]  run_ts
);
    // Run state: open on the first hit, extend on later hits, close otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_run  <= 1'b0;
            run_len <= '0;
            run_ts  <= '0;
        end else if (hit) begin
            if (!in_run) begin
                in_run  <= 1'b1;
                run_len <= CNT_W'(1);
                run_ts  <= ts;
            end else if (run_len != '1) begin
                run_len <= run_len + 1'b1;
            end
        end else begin
            in_run <= 1'b0;
        end
    end

    // A run ends in the first cycle without a hit.
    assign close = in_run && !hit;
endmodule

// File: rtl/wel_unit_stats.sv
// Per-unit statistics: saturating error, single, burst and drop counts,
// the unit number, and the failure flag. Cleared on the last unit cycle.
// Assumes: FAIL_LIM is below 2^CNT_W-1.
module wel_unit_stats #(
    parameter int CNT_W    = 16,
    parameter int UNIT_W   = 16,
    parameter int FAIL_LIM = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              close,
    input  logic              close_single,
    input  logic              drop,
    input  logic              unit_end,
    output logic [CNT_W-1:0]  total,
    output logic [CNT_W-1:0]  n_single,
    output logic [CNT_W-1:0]  n_burst,
    output logic [CNT_W-1:0]  n_drop,
    output logic [UNIT_W-1:0] unit_idx,
    output logic              fail
);
    // Counter update: clear at unit end, otherwise saturating increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total    <= '0;
            n_single <= '0;
            n_burst  <= '0;
            n_drop   <= '0;
            unit_idx <= '0;
        end else if (unit_end) begin
            total    <= '0;
            n_single <= '0;
            n_burst  <= '0;
            n_drop   <= '0;
            unit_idx <= unit_idx + 1'b1;
        end else begin
            if (hit && total != '1)                      total    <= total + 1'b1;
            if (close && close_single && n_single != '1) n_single <= n_single + 1'b1;
            if (close && !close_single && n_burst != '1) n_burst  <= n_burst + 1'b1;
            if (drop && n_drop != '1)                    n_drop   <= n_drop + 1'b1;
        end
    end

    // Functional failure: strictly more errors than the limit.
    assign fail = (total > CNT_W'(FAIL_LIM));
endmodule

// File: rtl/wel_fifo.sv
// Record FIFO: synchronous, registered storage, first-word presented
// directly from memory. Pushes into a full FIFO are ignored.
// Assumes: DEPTH >= 2.
module wel_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop_ready,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign do_pop    = out_valid && pop_ready;
    assign do_push   = push && (count != CW'(DEPTH));

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/word_err_logger.sv
// Timestamped word error logger (top). Compares received against expected
// words during the active window, logs each mismatch, each ended run and a
// per-unit summary into one record stream.
// Assumes: the consumer drains the summary before the next unit ends.
module word_err_logger
    import wel_pkg::*;
#(
    parameter int          DW         = 18,
    parameter int unsigned ACT_CYC    = 950_000_000,
    parameter int unsigned PD_CYC     = 50_000_000,
    parameter int          CNT_W      = 16,
    parameter int          UNIT_W     = 16,
    parameter int          FAIL_LIM   = 1000,
    parameter int          FIFO_DEPTH = 16,
    localparam int TS_W  = $clog2(ACT_CYC + PD_CYC),
    localparam int PAY_W = wmax(wmax(TS_W + 2 * DW, TS_W + CNT_W), UNIT_W + 4 * CNT_W + 1),
    localparam int REC_W = PAY_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    rx_word,
    input  logic [DW-1:0]    ref_word,
    output logic             pd_o,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [REC_W-1:0] rec_data
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    logic [TS_W-1:0]   ts;
    logic              unit_end;
    logic              hit, in_run, trk_close;
    logic [CNT_W-1:0]  trk_len;
    logic [TS_W-1:0]   trk_ts;
    logic [CNT_W-1:0]  st_total, st_single, st_burst, st_drops;
    logic [UNIT_W-1:0] st_unit;
    logic              st_fail;
    logic [FCW-1:0]    fifo_cnt;
    logic              rec_push, room, drop, fifo_push;
    wel_kind_e         kind;
    logic [PAY_W-1:0]  pay;

    wel_timebase #(.ACT_CYC(ACT_CYC), .PD_CYC(PD_CYC), .TS_W(TS_W)) u_time (
        .clk(clk), .rst_n(rst_n), .ts(ts), .pd(pd_o), .unit_end(unit_end)
    );

    // Comparison is live only in the active window.
    assign hit = !pd_o && (rx_word != ref_word);

    wel_run_track #(.TS_W(TS_W), .CNT_W(CNT_W)) u_run (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ts(ts), .in_run(in_run),
        .close(trk_close), .run_len(trk_len), .run_ts(trk_ts)
    );

    // Per-word and run records leave one entry free for the summary.
    assign rec_push  = hit || trk_close;
    assign room      = (fifo_cnt < FCW'(FIFO_DEPTH - 1));
    assign drop      = rec_push && !room;
    assign fifo_push = (rec_push && room) || unit_end;

    wel_unit_stats #(.CNT_W(CNT_W), .UNIT_W(UNIT_W), .FAIL_LIM(FAIL_LIM)) u_stats (
        .clk(clk), .rst_n(rst_n), .hit(hit), .close(trk_close),
        .close_single(trk_len == CNT_W'(1)), .drop(drop), .unit_end(unit_end),
        .total(st_total), .n_single(st_single), .n_burst(st_burst),
        .n_drop(st_drops), .unit_idx(st_unit), .fail(st_fail)
    );

    // Record assembly: at most one source is active in any cycle.
    always_comb begin
        if (unit_end) begin
            kind = REC_SUMMARY;
            pay  = PAY_W'({st_unit, st_total, st_single, st_burst, st_drops, st_fail});
        end else if (hit) begin
            kind = REC_WORD;
            pay  = PAY_W'({ts, ref_word, rx_word});
        end else begin
            kind = (trk_len == CNT_W'(1)) ? REC_SINGLE : REC_BURST;
            pay  = PAY_W'({trk_ts, trk_len});
        end
    end

    wel_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH), .CW(FCW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data({kind, pay}),
        .pop_ready(rec_ready), .out_valid(rec_valid), .out_data(rec_data),
        .count(fifo_cnt)
    );
endmodule

// File: rtl/wel_checker.sv
// Protocol and state checks for the word error logger, bound to the top.
module wel_checker #(
    parameter int REC_W = 8,
    parameter int TS_W  = 8,
    parameter int CNT_W = 8,
    parameter int FCW   = 4,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_o,
    input logic             unit_end,
    input logic [TS_W-1:0]  ts,
    input logic             in_run,
    input logic             trk_close,
    input logic [CNT_W-1:0] trk_len,
    input logic [CNT_W-1:0] st_total,
    input logic [CNT_W-1:0] st_drops,
    input logic [FCW-1:0]   fifo_cnt,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [REC_W-1:0] rec_data
);
    a_r10_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FCW'(DEPTH));

    a_r5_run_closed_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o && $past(pd_o) |-> !in_run);

    a_r6_counts_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(unit_end) |-> st_total == '0 && st_drops == '0);

    a_r2_pd_leave_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_o) |-> ts == '0);

    a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        trk_close |-> trk_len != '0);
endmodule

bind word_err_logger wel_checker #(
    .REC_W(REC_W), .TS_W(TS_W), .CNT_W(CNT_W), .FCW(FCW), .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_o(pd_o), .unit_end(unit_end), .ts(ts),
    .in_run(in_run), .trk_close(trk_close), .trk_len(trk_len),
    .st_total(st_total), .st_drops(st_drops), .fifo_cnt(fifo_cnt),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data)
);

// File: tb/word_err_logger_tb_top.sv
// Bench: six short units with distinct error patterns, a stalled unit and a
// toggling-ready unit; expected records are built from the requirements.
module word_err_logger_tb_top;
    localparam int ACT = 20, PD = 4, UNIT = ACT + PD;
    localparam int DW = 18, CNT_W = 4, UNIT_W = 4, FAIL = 5, DEPTH = 4;
    localparam int TS_W = 5;
    localparam int PAY_W = 41, REC_W = 43;

    logic clk = 1'b0, rst_n = 1'b0, rec_ready = 1'b1;
    logic [DW-1:0] rx_word = '0, ref_word = '0;
    logic pd_o, rec_valid;
    logic [REC_W-1:0] rec_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [REC_W-1:0] exp_q[$];
    string            tag_q[$];

    // model state
    bit in_run = 0;
    int run_len = 0, run_ts = 0, tot = 0, ns = 0, nb = 0, nd = 0, occ = 0;
    bit stalling = 0;

    always #10 clk = ~clk;

    word_err_logger #(
        .DW(DW), .ACT_CYC(ACT), .PD_CYC(PD), .CNT_W(CNT_W), .UNIT_W(UNIT_W),
        .FAIL_LIM(FAIL), .FIFO_DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .ref_word(ref_word),
        .pd_o(pd_o), .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] err_mask(input int u, input int t);
        case (u)
            1: if (t == 2) return 18'h20000;                 // R11 control-flag bit
               else if (t >= 5 && t <= 7) return 18'(1 << t);
               else if (t == 19) return 18'h0ff00;
            2: if (t >= 4 && t <= 11) return 18'(18'h10000 | t);
            3: if (t >= 3 && t <= 12) return 18'h00100;
            4: if (t == 8 || t == 14) return 18'h00002;
               else if (t == 18 || t == 19) return 18'h3ffff;
            5: return 18'h00040;
            default: ;
        endcase
        return '0;
    endfunction

    task automatic mpush(input logic [REC_W-1:0] r, input string tag, input bit is_sum);
        if (stalling && !is_sum) begin
            if (occ < DEPTH - 1) begin
                exp_q.push_back(r); tag_q.push_back(tag); occ++;
            end else if (nd < 15) nd++;
        end else begin
            exp_q.push_back(r); tag_q.push_back(tag);
            if (stalling) occ++;
        end
    endtask

    // Model of one cycle's effect at the following clock edge.
    task automatic model(input int u, input int t, input logic [DW-1:0] rf, input logic [DW-1:0] rx);
        bit hit;
        hit = (t < ACT) && (rf != rx);                          // R3: ignored in powerdown
        if (hit) begin
            mpush({2'd0, PAY_W'({TS_W'(t), rf, rx})}, (u == 1 && t == 2) ? "R11" : "R4", 0);
            if (tot < 15) tot++;
            if (!in_run) begin in_run = 1; run_len = 1; run_ts = t; end
            else if (run_len < 15) run_len++;
        end else if (in_run) begin
            in_run = 0;
            if (run_len == 1) ns++; else nb++;
            mpush({(run_len == 1) ? 2'd1 : 2'd2, PAY_W'({TS_W'(run_ts), CNT_W'(run_len)})},
                  (u == 5) ? "R8" : "R5", 0);
        end
        if (t == UNIT - 1) begin
            mpush({2'd3, PAY_W'({UNIT_W'(u), CNT_W'(tot), CNT_W'(ns), CNT_W'(nb), CNT_W'(nd),
                   (tot > FAIL) ? 1'b1 : 1'b0})},
                  (u == 1 || u == 2) ? "R7" : (u == 3) ? "R9" : (u == 5) ? "R8" : "R6", 1);
            tot = 0; ns = 0; nb = 0; nd = 0;
        end
    endtask

    initial begin
        logic [REC_W-1:0] prev;
        bit prev_stall;
        prev = '0; prev_stall = 0;
        repeat (3) begin
            @(negedge clk);
            chk(!rec_valid && !pd_o, "R1", {rec_valid, pd_o}, 0);
        end
        for (int c = 0; c < 6 * UNIT + 8; c++) begin
            int u, t;
            logic [DW-1:0] rf, m;
            bit rdy;
            u = c / UNIT; t = c % UNIT;
            @(negedge clk);
            rst_n = 1'b1;
            rdy = (u == 3 && t >= 2) ? 1'b0 : (u == 4 && t >= 4) ? t[0] : 1'b1;
            stalling = (u == 3 && t >= 2);
            if (u == 3 && t == 2) occ = 0;
            rec_ready = rdy;
            rf = 18'((u * 97 + t * 31 + 3) * 1237);
            m  = (t < ACT) ? err_mask(u, t) : 18'h3ffff;       // garbage in powerdown
            ref_word = rf;
            rx_word  = rf ^ m;
            chk(pd_o == (t >= ACT), "R2", pd_o, (t >= ACT));
            if (t >= ACT)                                        // R3
                chk(!(rec_valid && rec_data[REC_W-1 -: 2] == 2'd0 && int'(rec_data[2*DW +: TS_W]) >= ACT),
                    "R3", rec_data, 0);
            if (prev_stall)
                chk(rec_valid && rec_data == prev, "R10", rec_data, prev);
            prev_stall = rec_valid && !rdy;
            prev = rec_data;
            if (rec_valid && rdy) begin
                if (exp_q.size() == 0) chk(1'b0, "R10", rec_data, 0);
                else begin
                    logic [REC_W-1:0] e;
                    string tg;
                    e = exp_q.pop_front(); tg = tag_q.pop_front();
                    chk(rec_data == e, tg, rec_data, e);
                end
            end
            model(u, t, rf, rf ^ m);
        end
        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule